// File: doc/BRIEF.md
# Switch-Timed Lamp Colour Controller

This block chooses the colour of a lamp built from two white LED groups and two yellow LED groups. There is no colour selector. The user picks a colour with the single wall switch alone, by opening it briefly and closing it again. The block watches a debounced, synchronised switch level. It measures how long each open interval lasts in whole milliseconds, and from that length it either steps through a short cycle of colours or falls back to white.

The colour cycle is white, then daylight (both colours together), then yellow, then white again. A brief open interval of at most one second advances the lamp one step. Any open interval longer than one second returns the lamp to white. While the switch is open the lamp is dark. The millisecond timebase is divided down from the clock frequency parameter, so the same logic serves any clock rate.

Top module: `lamp_colour_switch`

## Requirements
- R1: The outputs carry three lit patterns only. White drives `led_white`=2'b11 and `led_yellow`=2'b00. Daylight drives both buses to 2'b11. Yellow drives `led_white`=2'b00 and `led_yellow`=2'b11.
- R2: While `sw_closed` is low, both LED buses are 2'b00 from the clock edge that samples the switch open.
- R3: The first closure after reset lights white.
- R4: White, then an open interval counted as short, then a closure, gives daylight.
- R5: Daylight, then a short open interval, then a closure, gives yellow.
- R6: Yellow, then any open interval, then a closure, gives white.
- R7: An open interval counted as long gives white on the next closure, whatever the previous colour was.
- R8: The open interval is counted in whole milliseconds of CLK_HZ/1000 clock cycles, starting from the first clock edge that samples the switch open. It counts as short while at most GAP_MS whole milliseconds have elapsed, so exactly 1000 ms is short. It counts as long from GAP_MS+1 elapsed milliseconds on.
- R9: The interval timer saturates. However long the switch stays open, the next closure gives white.
- R10: Synchronous active-high `rst` turns both buses off and makes the next closure light white.
- R11: The lamp lights on the first clock edge that samples `sw_closed` high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| sw_closed | input | 1 | Debounced switch level, high when closed |
| led_white | output | 2 | Enables for the two white LED groups |
| led_yellow | output | 2 | Enables for the two yellow LED groups |

## Verification
The bench builds the block with CLK_HZ=4000 and GAP_MS left at 1000. That makes one millisecond four clock cycles and puts the one-second decision at a few thousand cycles. With these values the bench can open the switch for exactly the last short count (4003 cycles) and the first long count (4004 cycles). It can also hold the switch open for 10000 cycles, which is past the point where an unsaturated 10-bit interval counter would wrap.

// File: rtl/lamp_pkg.sv
package lamp_pkg;

    localparam int unsigned LED_GROUPS = 2;

    typedef enum logic [1:0] {
        COL_WHITE    = 2'd0,
        COL_DAYLIGHT = 2'd1,
        COL_YELLOW   = 2'd2
    } colour_t;

    typedef struct packed {
        logic [LED_GROUPS-1:0] white;
        logic [LED_GROUPS-1:0] yellow;
    } led_drive_t;

    // Colour shown after a short open interval, given the colour shown before it.
    function automatic colour_t colour_step(colour_t c);
        case (c)
            COL_WHITE:    return COL_DAYLIGHT;
            COL_DAYLIGHT: return COL_YELLOW;
            default:      return COL_WHITE;
        endcase
    endfunction

    // LED group enables for one colour.
    function automatic led_drive_t colour_leds(colour_t c);
        led_drive_t d;
        d.white  = (c == COL_WHITE  || c == COL_DAYLIGHT) ? '1 : '0;
        d.yellow = (c == COL_YELLOW || c == COL_DAYLIGHT) ? '1 : '0;
        return d;
    endfunction

endpackage

// File: rtl/lamp_ms_tick.sv
module lamp_ms_tick #(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned TICK_HZ = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic tick
);
    localparam int unsigned DIV_RAW = CLK_HZ / TICK_HZ;
    localparam int unsigned DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
    localparam int unsigned CW      = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    // The divider restarts while held, so intervals are measured from their start.
    assign tick = !hold && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lamp_gap_timer.sv
module lamp_gap_timer #(
    parameter int unsigned LIMIT_MS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_closed,
    input  logic tick,
    output logic gap_long
);
    localparam int unsigned SAT = LIMIT_MS + 1;
    localparam int unsigned GW  = $clog2(SAT + 1);

    logic [GW-1:0] ms;

    always_ff @(posedge clk) begin
        if (rst || sw_closed) begin
            ms <= '0;
        end else if (tick && ms != GW'(SAT)) begin
            ms <= ms + 1'b1;
        end
    end

    assign gap_long = (ms == GW'(SAT));
endmodule

// File: rtl/lamp_colour_fsm.sv
module lamp_colour_fsm
    import lamp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_closed,
    input  logic       gap_long,
    output led_drive_t drive
);
    logic    closed;
    colour_t shown;
    colour_t pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            closed  <= 1'b0;
            shown   <= COL_WHITE;
            pending <= COL_WHITE;
        end else begin
            if (sw_closed && !closed) begin
                closed <= 1'b1;
                shown  <= gap_long ? COL_WHITE : pending;
            end else if (!sw_closed && closed) begin
                closed  <= 1'b0;
                pending <= colour_step(shown);
            end else if (!sw_closed && gap_long) begin
                pending <= COL_WHITE;
            end
        end
    end

    always_comb begin
        drive = closed ? colour_leds(shown) : '0;
    end
endmodule

// File: rtl/lamp_colour_switch.sv
module lamp_colour_switch
    import lamp_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned GAP_MS = 1000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sw_closed,
    output logic [LED_GROUPS-1:0] led_white,
    output logic [LED_GROUPS-1:0] led_yellow
);
    logic       ms_tick;
    logic       gap_long;
    led_drive_t drive;

    lamp_ms_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(1000)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .hold (sw_closed),
        .tick (ms_tick)
    );

    lamp_gap_timer #(.LIMIT_MS(GAP_MS)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .sw_closed (sw_closed),
        .tick      (ms_tick),
        .gap_long  (gap_long)
    );

    lamp_colour_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sw_closed (sw_closed),
        .gap_long  (gap_long),
        .drive     (drive)
    );

    assign led_white  = drive.white;
    assign led_yellow = drive.yellow;
endmodule

// File: rtl/lamp_colour_switch_chk.sv
module lamp_colour_switch_chk (
    input logic       clk,
    input logic       rst,
    input logic       sw_closed,
    input logic [1:0] led_white,
    input logic [1:0] led_yellow
);
    logic lit, lit_q, seen, prev_yellow;
    assign lit = (|led_white) || (|led_yellow);

    always_ff @(posedge clk) begin
        if (rst) begin
            lit_q       <= 1'b0;
            seen        <= 1'b0;
            prev_yellow <= 1'b0;
        end else begin
            lit_q <= lit;
            if (lit) begin
                seen        <= 1'b1;
                prev_yellow <= (led_white == 2'b00) && (led_yellow == 2'b11);
            end
        end
    end

    a_r1_legal_pattern: assert property (@(posedge clk) disable iff (rst)
        (led_white == 2'b00 || led_white == 2'b11) &&
        (led_yellow == 2'b00 || led_yellow == 2'b11));

    a_r2_dark_when_open: assert property (@(posedge clk) disable iff (rst)
        !sw_closed |=> !lit);

    a_r11_lit_after_close: assert property (@(posedge clk) disable iff (rst)
        sw_closed |=> lit);

    a_r3_first_is_white: assert property (@(posedge clk) disable iff (rst)
        (lit && !lit_q && !seen) |-> (led_white == 2'b11 && led_yellow == 2'b00));

    a_r6_yellow_then_white: assert property (@(posedge clk) disable iff (rst)
        (lit && !lit_q && prev_yellow) |-> (led_white == 2'b11 && led_yellow == 2'b00));
endmodule

bind lamp_colour_switch lamp_colour_switch_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_closed  (sw_closed),
    .led_white  (led_white),
    .led_yellow (led_yellow)
);

// File: tb/test_lamp_colour_switch.sv
`timescale 1ns/1ps
module test_lamp_colour_switch;
    localparam int unsigned CLK_HZ    = 4000;
    localparam int unsigned GAP_MS    = 1000;
    localparam int unsigned DIV       = CLK_HZ / 1000;
    localparam int          SHORT_MAX = DIV * (GAP_MS + 1) - 1;
    localparam int          LONG_MIN  = DIV * (GAP_MS + 1);

    localparam logic [3:0] P_OFF   = 4'b0000;
    localparam logic [3:0] P_WHITE = 4'b1100;
    localparam logic [3:0] P_DAY   = 4'b1111;
    localparam logic [3:0] P_YEL   = 4'b0011;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_closed = 1'b0;
    logic [1:0] led_white, led_yellow;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    lamp_colour_switch #(.CLK_HZ(CLK_HZ), .GAP_MS(GAP_MS)) i_lamp_colour_switch (
        .clk        (clk),
        .rst        (rst),
        .sw_closed  (sw_closed),
        .led_white  (led_white),
        .led_yellow (led_yellow)
    );

    task automatic chk(input string req, input logic [3:0] expv);
        logic [3:0] act;
        act = {led_white, led_yellow};
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: leds {white,yellow} = %b, expected %b", req, act, expv);
        end
    endtask

    // Called at a falling edge with the switch closed: open for n rising edges, then close.
    task automatic gap_then_close(input int n, input string req, input logic [3:0] expv);
        sw_closed = 1'b0;
        @(negedge clk);
        chk("R2", P_OFF);
        repeat (n - 1) @(negedge clk);
        chk("R2", P_OFF);
        sw_closed = 1'b1;
        #0.5;
        chk("R11", P_OFF);
        @(negedge clk);
        chk(req, expv);
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        chk("R10", P_OFF);
        rst = 1'b0;
        @(negedge clk);
        chk("R2", P_OFF);
    endtask

    task automatic t_first_closure();
        sw_closed = 1'b1;
        #0.5;
        chk("R11", P_OFF);
        @(negedge clk);
        chk("R3", P_WHITE);
        chk("R1", P_WHITE);
    endtask

    task automatic t_short_cycle();
        gap_then_close(40, "R4", P_DAY);
        gap_then_close(3,  "R5", P_YEL);
        gap_then_close(1,  "R6", P_WHITE);
        gap_then_close(100, "R4", P_DAY);
    endtask

    task automatic t_long_gap();
        gap_then_close(LONG_MIN + 20, "R7", P_WHITE);
        gap_then_close(8, "R4", P_DAY);
        gap_then_close(8, "R5", P_YEL);
        gap_then_close(LONG_MIN + 20, "R6", P_WHITE);
    endtask

    task automatic t_threshold();
        gap_then_close(DIV * GAP_MS, "R8", P_DAY);
        gap_then_close(SHORT_MAX, "R8", P_YEL);
        gap_then_close(5, "R6", P_WHITE);
        gap_then_close(4, "R4", P_DAY);
        gap_then_close(LONG_MIN, "R8", P_WHITE);
    endtask

    task automatic t_saturate();
        gap_then_close(10000, "R9", P_WHITE);
        gap_then_close(6, "R4", P_DAY);
    endtask

    task automatic t_mid_reset();
        rst = 1'b1;
        sw_closed = 1'b0;
        @(negedge clk);
        chk("R10", P_OFF);
        rst = 1'b0;
        @(negedge clk);
        sw_closed = 1'b1;
        @(negedge clk);
        chk("R10", P_WHITE);
    endtask

    initial begin
        t_reset_state();
        t_first_closure();
        t_short_cycle();
        t_long_gap();
        t_threshold();
        t_saturate();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule